// File: doc/BRIEF.md
# Synchronous Receive Character Stripper

This block sits between the character assembler of a synchronous serial receiver and its receive holding register. For every assembled character it decides whether the character is written to the holding register or discarded. It compares the character against three programmed patterns: the primary sync character, the secondary sync character and the link-escape character. When stripping is active, it discards sync fill and escape prefixes, so the host only sees payload.

The decision uses one character of history, stored as the class of the previous character. The secondary sync character is dropped only when it directly follows the primary one. In transparent operation, the primary sync character is dropped only when it directly follows an escape. An escape pair keeps its second escape as data. Sync and escape detection strobes for the status logic are raised whether or not the character is kept. A restart input, pulsed when the receiver is re-enabled or returns to hunt, clears the history.

The mode field `mode_i` uses two bits. Bit 0 set selects transparent operation. With bit 0 clear, bit 1 set selects single-sync operation and bit 1 clear selects double-sync operation. Stripping is active only while `sync_mode_i` is 1 and `submode_i` equals 2'b01.

Top module: `rx_char_stripper`

## Requirements
- R1: While and after reset, `hr_wr_o`, `hr_data_o`, `syn_det_o` and `dle_det_o` are all 0 until the first character is accepted.
- R2: When stripping is inactive (`sync_mode_i`=0 or `submode_i`≠2'b01), every character strobed on `char_valid_i` produces `hr_wr_o`=1 one clock later, with `hr_data_o` equal to that character.
- R3: With stripping active and `mode_i`=2'b10, a character equal to `syn1_i` is not written; all other characters are written.
- R4: With stripping active and `mode_i`=2'b00, a character equal to `syn1_i` is not written, and a character equal to `syn2_i` is not written only when the previous character was equal to `syn1_i`.
- R5: With stripping active and `mode_i[0]`=1, a character equal to `dle_i` is not written unless the previous character was a discarded escape; a character equal to `syn1_i` is not written only when the previous character was an escape.
- R6: In transparent operation, the kept second escape of a pair resets the history, so a third consecutive escape is again discarded.
- R7: `syn_det_o` pulses one clock after every character equal to `syn1_i`. `dle_det_o` pulses one clock after every character equal to `dle_i` while `mode_i[0]`=1. Both pulses occur whether or not the character is stripped.
- R8: `hr_data_o` holds its value in every cycle where `hr_wr_o` is 0.
- R9: A `restart_i` pulse clears the history to "other". A character presented in the same cycle as `restart_i` produces no write and no detection.
- R10: A cycle without `char_valid_i` produces no write and no detection, and leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Clears history on receiver enable or hunt entry |
| char_valid_i | input | 1 | Assembled character strobe |
| char_data_i | input | W | Assembled character |
| syn1_i | input | W | Primary sync pattern |
| syn2_i | input | W | Secondary sync pattern |
| dle_i | input | W | Escape pattern |
| sync_mode_i | input | 1 | 1 = synchronous operation |
| submode_i | input | 2 | Submode; 2'b01 enables stripping |
| mode_i | input | 2 | Bit 0 transparent; bit 1 single-sync when not transparent |
| hr_wr_o | output | 1 | Holding-register write strobe |
| hr_data_o | output | W | Data for the holding register |
| syn_det_o | output | 1 | Sync detection strobe |
| dle_det_o | output | 1 | Escape detection strobe |

## Verification
The assertions assume that the three patterns are distinct from each other. They also assume that the patterns and the mode inputs stay steady while characters arrive, because the decision for a character is judged against the configuration registered with it. The stimulus programs four distinct byte values and changes the configuration only between sweeps. Each sequence is opened with a restart, so every sweep starts from a known history.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic [1:0] {
    HIST_OTHER = 2'd0,
    HIST_SYN1  = 2'd1,
    HIST_DLE   = 2'd2
  } hist_e;

  localparam int unsigned NPAT     = 3;
  localparam int unsigned PAT_SYN1 = 0;
  localparam int unsigned PAT_SYN2 = 1;
  localparam int unsigned PAT_DLE  = 2;
  localparam logic [1:0]  SUB_STRIP = 2'b01;
endpackage

// File: rtl/strip_match.sv
module strip_match
  import strip_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]    data_i,
  input  logic [W-1:0]    syn1_i,
  input  logic [W-1:0]    syn2_i,
  input  logic [W-1:0]    dle_i,
  output logic [NPAT-1:0] hit_o
);
  logic [W-1:0] pat [NPAT];

  assign pat[PAT_SYN1] = syn1_i;
  assign pat[PAT_SYN2] = syn2_i;
  assign pat[PAT_DLE]  = dle_i;

  for (genvar g = 0; g < NPAT; g++) begin : g_cmp
    assign hit_o[g] = (data_i == pat[g]);
  end
endmodule

// File: rtl/strip_decide.sv
module strip_decide
  import strip_pkg::*;
(
  input  logic [NPAT-1:0] hit_i,
  input  hist_e           prev_i,
  input  logic            transparent_i,
  input  logic            single_syn_i,
  input  logic            strip_act_i,
  output logic            drop_o,
  output hist_e           next_o
);
  logic is_syn1, is_syn2, is_dle, drop_raw;

  assign is_syn1 = hit_i[PAT_SYN1];
  assign is_syn2 = hit_i[PAT_SYN2];
  assign is_dle  = hit_i[PAT_DLE];

  always_comb begin
    drop_raw = 1'b0;
    next_o   = HIST_OTHER;
    if (transparent_i) begin
      if (is_dle) begin
        // second escape of a pair is data and closes the pair
        if (prev_i == HIST_DLE) begin
          drop_raw = 1'b0;
          next_o   = HIST_OTHER;
        end else begin
          drop_raw = 1'b1;
          next_o   = HIST_DLE;
        end
      end else if (is_syn1) begin
        drop_raw = (prev_i == HIST_DLE);
        next_o   = HIST_SYN1;
      end
    end else begin
      next_o   = is_syn1 ? HIST_SYN1 : HIST_OTHER;
      drop_raw = is_syn1 | (!single_syn_i && is_syn2 && prev_i == HIST_SYN1);
    end
  end

  assign drop_o = strip_act_i & drop_raw;
endmodule

// File: rtl/strip_history.sv
module strip_history
  import strip_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  adv_i,
  input  hist_e next_i,
  output hist_e prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_o <= HIST_OTHER;
    else if (clear_i) prev_o <= HIST_OTHER;
    else if (adv_i)   prev_o <= next_i;
  end
endmodule

// File: rtl/rx_char_stripper.sv
module rx_char_stripper
  import strip_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         char_valid_i,
  input  logic [W-1:0] char_data_i,
  input  logic [W-1:0] syn1_i,
  input  logic [W-1:0] syn2_i,
  input  logic [W-1:0] dle_i,
  input  logic         sync_mode_i,
  input  logic [1:0]   submode_i,
  input  logic [1:0]   mode_i,
  output logic         hr_wr_o,
  output logic [W-1:0] hr_data_o,
  output logic         syn_det_o,
  output logic         dle_det_o
);
  logic [NPAT-1:0] hit;
  hist_e           prev, next;
  logic            drop, strip_act, transparent, accept;

  assign strip_act   = sync_mode_i && (submode_i == SUB_STRIP);
  assign transparent = mode_i[0];
  assign accept      = char_valid_i && !restart_i;

  strip_match #(.W(W)) u_match (
    .data_i (char_data_i),
    .syn1_i (syn1_i),
    .syn2_i (syn2_i),
    .dle_i  (dle_i),
    .hit_o  (hit)
  );

  strip_decide u_decide (
    .hit_i         (hit),
    .prev_i        (prev),
    .transparent_i (transparent),
    .single_syn_i  (mode_i[1]),
    .strip_act_i   (strip_act),
    .drop_o        (drop),
    .next_o        (next)
  );

  strip_history u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart_i),
    .adv_i   (accept),
    .next_i  (next),
    .prev_o  (prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hr_wr_o   <= 1'b0;
      hr_data_o <= '0;
      syn_det_o <= 1'b0;
      dle_det_o <= 1'b0;
    end else begin
      hr_wr_o   <= accept && !drop;
      syn_det_o <= accept && hit[PAT_SYN1];
      dle_det_o <= accept && transparent && hit[PAT_DLE];
      if (accept && !drop) hr_data_o <= char_data_i;
    end
  end
endmodule

// File: rtl/strip_chk.sv
module strip_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         restart_i,
  input logic         char_valid_i,
  input logic [W-1:0] char_data_i,
  input logic [W-1:0] syn1_i,
  input logic [W-1:0] dle_i,
  input logic         sync_mode_i,
  input logic [1:0]   submode_i,
  input logic [1:0]   mode_i,
  input logic         hr_wr_o,
  input logic [W-1:0] hr_data_o,
  input logic         syn_det_o,
  input logic         dle_det_o
);
  // R9 R10
  wr_needs_char_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hr_wr_o |-> $past(char_valid_i && !restart_i));

  // R2
  pass_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !restart_i && !(sync_mode_i && submode_i == 2'b01))
      |=> (hr_wr_o && hr_data_o == $past(char_data_i)));

  // R3
  single_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !restart_i && sync_mode_i && submode_i == 2'b01 &&
     mode_i == 2'b10 && char_data_i == syn1_i) |=> !hr_wr_o);

  // R7
  syn_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_det_o |-> $past(char_valid_i && !restart_i && char_data_i == syn1_i));

  // R7
  dle_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !restart_i && mode_i[0] && char_data_i == dle_i) |=> dle_det_o);

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hr_wr_o |-> $stable(hr_data_o));
endmodule

bind rx_char_stripper strip_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .restart_i    (restart_i),
  .char_valid_i (char_valid_i),
  .char_data_i  (char_data_i),
  .syn1_i       (syn1_i),
  .dle_i        (dle_i),
  .sync_mode_i  (sync_mode_i),
  .submode_i    (submode_i),
  .mode_i       (mode_i),
  .hr_wr_o      (hr_wr_o),
  .hr_data_o    (hr_data_o),
  .syn_det_o    (syn_det_o),
  .dle_det_o    (dle_det_o)
);

// File: tb/sim_rx_char_stripper.sv
`timescale 1ns/1ps
module sim_rx_char_stripper;
  localparam int W = 8;
  localparam logic [7:0] S1 = 8'h16, S2 = 8'h26, DL = 8'h10, OT = 8'h5A;

  logic clk = 0, rst_ni = 0;
  logic restart = 0, cv = 0;
  logic [W-1:0] cd = '0;
  logic sync_mode = 0;
  logic [1:0] submode = 0, mode = 0;
  logic hr_wr, syn_det, dle_det;
  logic [W-1:0] hr_data;

  int n_cmp = 0, n_bad = 0;
  int prev_m = 0;            // 0 other, 1 syn1, 2 dle
  logic [7:0] last_data = '0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_char_stripper #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart), .char_valid_i(cv),
    .char_data_i(cd), .syn1_i(S1), .syn2_i(S2), .dle_i(DL),
    .sync_mode_i(sync_mode), .submode_i(submode), .mode_i(mode),
    .hr_wr_o(hr_wr), .hr_data_o(hr_data), .syn_det_o(syn_det), .dle_det_o(dle_det)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic r);
    @(negedge clk);
    cv = v; cd = d; restart = r;
    @(posedge clk);
    #2;
  endtask

  task automatic check_out(input bit ew, input bit es, input bit ed, input string req);
    chk(hr_wr == ew, {req, " wr"}, hr_wr, ew);
    chk(syn_det == es, "R7 syn_det", syn_det, es);
    chk(dle_det == ed, "R7 dle_det", dle_det, ed);
    chk(hr_data == last_data, "R8 hr_data", hr_data, last_data);
  endtask

  task automatic feed(input logic [7:0] d);
    bit act, tr, drop, s1, s2, dl;
    int nxt;
    act = sync_mode && submode == 2'b01;
    tr = mode[0];
    s1 = (d == S1); s2 = (d == S2); dl = (d == DL);
    drop = 0; nxt = 0;
    if (tr) begin
      if (dl) begin
        if (prev_m == 2) begin drop = 0; nxt = 0; end   // R6
        else begin drop = 1; nxt = 2; end               // R5
      end else if (s1) begin
        drop = (prev_m == 2); nxt = 1;
      end
    end else begin
      nxt = s1 ? 1 : 0;
      drop = s1 || (!mode[1] && s2 && prev_m == 1);     // R3 R4
    end
    if (!act) drop = 0;                                 // R2
    prev_m = nxt;
    step(1, d, 0);
    if (!drop) last_data = d;
    check_out(!drop, s1, tr && dl, act ? (tr ? "R5" : (mode[1] ? "R3" : "R4")) : "R2");
  endtask

  initial begin
    logic [7:0] sym [4];
    sym[0] = S1; sym[1] = S2; sym[2] = DL; sym[3] = OT;
    #23;
    // R1
    chk(hr_wr == 0 && syn_det == 0 && dle_det == 0 && hr_data == 0, "R1 reset", hr_wr, 0);
    rst_ni = 1;
    step(0, 8'h00, 0);
    check_out(0, 0, 0, "R1");

    for (int cfg = 0; cfg < 6; cfg++) begin
      @(negedge clk);
      case (cfg)
        0: begin sync_mode = 1; submode = 2'b01; mode = 2'b00; end
        1: begin sync_mode = 1; submode = 2'b01; mode = 2'b10; end
        2: begin sync_mode = 1; submode = 2'b01; mode = 2'b01; end
        3: begin sync_mode = 1; submode = 2'b01; mode = 2'b11; end
        4: begin sync_mode = 1; submode = 2'b00; mode = 2'b01; end
        default: begin sync_mode = 0; submode = 2'b01; mode = 2'b00; end
      endcase
      for (int s = 0; s < 256; s++) begin
        step(0, 8'h00, 1);
        prev_m = 0;
        check_out(0, 0, 0, "R9");
        for (int k = 0; k < 4; k++) begin
          feed(sym[(s >> (2*k)) & 3]);
          if (k == 1) begin
            // R10: idle cycle leaves history alone
            step(0, sym[0], 0);
            check_out(0, 0, 0, "R10");
          end
        end
      end
    end

    // R9: restart cycle char is discarded and history cleared
    @(negedge clk);
    sync_mode = 1; submode = 2'b01; mode = 2'b01;
    step(0, 8'h00, 1); prev_m = 0;
    feed(DL);
    step(1, DL, 1); prev_m = 0;
    check_out(0, 0, 0, "R9");
    feed(DL);
    chk(hr_wr == 0, "R9 escape after restart", hr_wr, 0);
    // R6 explicit: third escape dropped
    feed(DL);
    chk(hr_wr == 1, "R6 second escape kept", hr_wr, 1);
    feed(DL);
    chk(hr_wr == 0, "R6 third escape dropped", hr_wr, 0);

    step(0, 8'h00, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule